// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block is a clock divider driven by one configuration word. The word holds a divider hold bit, a run enable, a divide-by-16 prescaler select, a source select and a twelve-bit count field. The generator takes ticks from the selected source, optionally divides them by 16, and counts them out to make an output clock. The output frequency is the source tick rate divided by the effective ratio. The count field stores the ratio minus one, so a field of zero divides by one.

Source 0 is the internal reference, which ticks on every core clock. Sources 1 to 3 are qualifying enables on `ext_tick`. One of these can be wired to another generator's `out_tick`, so that generators chain. A separate combinational helper turns a requested overall ratio into a prescaler bit and a count field. Software can place that result straight into the configuration word.

There is no streaming data path. All pins are plain control and status pins with no handshake.

Top module: `baud_rate_gen`

## Requirements
- R1: After `rst_n` is released, `cfg_rdata` is 0, `out_clk` is 0 and `out_tick` is 0.
- R2: A word written with `cfg_wr` reads back unchanged on `cfg_rdata` from the following cycle. Bit positions are: bit 0 hold, bits 12:1 count field, bit 13 prescaler select, bits 15:14 source select, bit 16 enable. The hold bit reads 0 once software clears it.
- R3: With the internal source, the enable set and the prescaler off, `out_tick` pulses for one cycle every F+1 clock cycles, where F is the count field.
- R4: With the prescaler on, the `out_tick` period is 16 × (F+1) source ticks.
- R5: For an effective ratio N ≥ 2, each output period holds `out_clk` high for ceil(N/2) prescaled ticks and low for floor(N/2). The period starts high, together with `out_tick`. For N = 1, `out_clk` stays high.
- R6: While the hold bit is 1, `out_clk` is 0 and `out_tick` stays 0. After the hold bit is cleared, the first `out_tick` follows after exactly N prescaled ticks.
- R7: While the enable bit is 0, `out_tick` stays 0 and `out_clk` holds its value. The stored count field keeps its value.
- R8: Source select 0 counts every clock cycle. A source select s of 1 to 3 counts only the cycles in which `ext_tick[s-1]` is 1. Unselected inputs have no effect.
- R9: A count field written while the generator runs takes effect at the next wrap. The period in progress completes with the old ratio.
- R10: For a requested ratio r from 1 to 65536: if r > 4096, then `enc_div16` = 1 and `enc_count` = r/16 − 1 (integer division). Otherwise `enc_div16` = 0 and `enc_count` = r − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the internal reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 17 | Configuration word to write |
| cfg_rdata | output | 17 | Stored configuration word |
| ext_tick | input | 3 | External source enables, one per source 1..3 |
| out_clk | output | 1 | Divided output clock |
| out_tick | output | 1 | One-cycle pulse at the start of each output period |
| ratio_req | input | 17 | Requested overall division ratio for the encoder helper |
| enc_div16 | output | 1 | Encoder result: prescaler select |
| enc_count | output | 12 | Encoder result: count field |

## Verification
A corrupted period counter or a stale shadow count shows up as a wrong spacing between `out_tick` pulses. The error is visible within one output period, or within two when the field was just changed. A prescaler that is stuck or skips ticks scales that spacing by a factor other than 16. A wrong high/low split appears as a wrong count of high samples on `out_clk` within a single period. A hold or enable bit that fails to gate the counter shows up at once as a stray `out_tick`.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int CNT_W   = 12;
  localparam int PRE_W   = 4;
  localparam int SRC_W   = 2;
  localparam int HOLD_B  = 0;
  localparam int CNT_LSB = 1;
  localparam int PRE_B   = CNT_LSB + CNT_W;
  localparam int SRC_LSB = PRE_B + 1;
  localparam int EN_B    = SRC_LSB + SRC_W;
  localparam int REG_W   = EN_B + 1;
  localparam int RATIO_W = CNT_W + PRE_W + 1;

  typedef struct packed {
    logic             div16;
    logic [CNT_W-1:0] field;
  } enc_t;

  function automatic enc_t encode_ratio(input logic [RATIO_W-1:0] r);
    enc_t e;
    logic [RATIO_W-1:0] q;
    if (r > RATIO_W'(2 ** CNT_W)) begin
      q       = (r >> PRE_W) - 1'b1;
      e.div16 = 1'b1;
      e.field = q[CNT_W-1:0];
    end else begin
      q       = r - 1'b1;
      e.div16 = 1'b0;
      e.field = q[CNT_W-1:0];
    end
    return e;
  endfunction
endpackage

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));
endmodule

// File: rtl/brg_tick_sel.sv
module brg_tick_sel #(
  parameter int SEL_W = 2,
  parameter int EXT_N = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [EXT_N-1:0] ext_tick,
  output logic             tick
);
  localparam int LANES = EXT_N + 1;
  logic [LANES-1:0] lane;

  assign lane[0] = 1'b1;
  for (genvar g = 0; g < EXT_N; g++) begin : g_lane
    assign lane[g+1] = ext_tick[g];
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (int'(sel) == i) tick = lane[i];
  end
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic div16,
  output logic pulse
);
  logic [PW-1:0] pre;

  assign pulse = div16 ? (tick && (&pre)) : tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre <= '0;
    else if (clr)            pre <= '0;
    else if (tick && div16)  pre <= pre + 1'b1;
  end
endmodule

// File: rtl/brg_period_ctr.sv
module brg_period_ctr #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pulse,
  input  logic [CW-1:0] load_val,
  output logic          out_clk,
  output logic          out_tick
);
  logic [CW-1:0] cnt, cur;
  logic [CW:0]   hi_len, nxt;

  assign hi_len = ({1'b0, cur} + 2'd2) >> 1;
  assign nxt    = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cur <= '0; out_clk <= 1'b0; out_tick <= 1'b0;
    end else if (clr) begin
      cnt <= '0; cur <= load_val; out_clk <= 1'b0; out_tick <= 1'b0;
    end else if (pulse) begin
      if (cnt == cur) begin
        cnt      <= '0;
        cur      <= load_val;
        out_clk  <= 1'b1;
        out_tick <= 1'b1;
      end else begin
        cnt      <= nxt[CW-1:0];
        out_clk  <= nxt < hi_len;
        out_tick <= 1'b0;
      end
    end else begin
      out_tick <= 1'b0;
    end
  end

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur);

  // R5
  period_starts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> out_clk);
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import brg_pkg::*;
#(
  parameter int EXT_N = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic [EXT_N-1:0]   ext_tick,
  output logic               out_clk,
  output logic               out_tick,
  input  logic [RATIO_W-1:0] ratio_req,
  output logic               enc_div16,
  output logic [CNT_W-1:0]   enc_count
);
  logic [REG_W-1:0] cfg_q;
  logic src_tick, gated_tick, pre_pulse, hold, run;
  enc_t enc;

  brg_cfg_reg #(.W(REG_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .q(cfg_q));

  assign cfg_rdata = cfg_q;
  assign hold      = cfg_q[HOLD_B];
  assign run       = cfg_q[EN_B];

  brg_tick_sel #(.SEL_W(SRC_W), .EXT_N(EXT_N)) sel_i (
    .sel(cfg_q[SRC_LSB +: SRC_W]), .ext_tick(ext_tick), .tick(src_tick));

  assign gated_tick = src_tick && run && !hold;

  brg_prescale #(.PW(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .clr(hold), .tick(gated_tick),
    .div16(cfg_q[PRE_B]), .pulse(pre_pulse));

  brg_period_ctr #(.CW(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(hold), .pulse(pre_pulse),
    .load_val(cfg_q[CNT_LSB +: CNT_W]), .out_clk(out_clk), .out_tick(out_tick));

  assign enc       = encode_ratio(ratio_req);
  assign enc_div16 = enc.div16;
  assign enc_count = enc.field;

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !out_tick && !out_clk);

  // R7
  disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |=> $stable(out_clk) && !out_tick);

  // R10
  always_comb begin
    if (ratio_req >= RATIO_W'(1) && ratio_req <= RATIO_W'(2 ** (CNT_W + PRE_W))) begin
      enc_ratio_chk: assert ((enc_div16 ? (32'(enc_count) + 1) * 16 : 32'(enc_count) + 1)
                             <= 32'(ratio_req)
                             && 32'(ratio_req) - (enc_div16 ? (32'(enc_count) + 1) * 16
                                                  : 32'(enc_count) + 1) < 16);
    end
  end
endmodule

// File: tb/baud_rate_gen_tb_top.sv
module baud_rate_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic [16:0] cfg_rdata;
  logic [2:0]  ext_tick = '0;
  logic        out_clk, out_tick;
  logic [16:0] ratio_req = '0;
  logic        enc_div16;
  logic [11:0] enc_count;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  baud_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ext_tick(ext_tick), .out_clk(out_clk),
    .out_tick(out_tick), .ratio_req(ratio_req), .enc_div16(enc_div16),
    .enc_count(enc_count));

  function automatic logic [16:0] mk(input int hold, input int cnt, input int pre,
                                     input int src, input int en);
    return 17'((en << 16) | (src << 14) | (pre << 13) | (cnt << 1) | hold);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!out_tick) @(negedge clk);
  endtask

  task automatic meas(output int per, output int hi);
    wait_tick();
    per = 0; hi = 0;
    do begin
      if (out_clk) hi++;
      per++;
      @(negedge clk);
    end while (!out_tick);
  endtask

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      ext_tick[0] = (c % 3) == 0;
      ext_tick[1] = (c % 5) == 0;
      ext_tick[2] = (c % 2) == 0;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cfg_rdata == 0 && !out_clk && !out_tick, "R1", cfg_rdata, 0);

    // R2 readback of several patterns
    wr(mk(1, 12'hABC, 1, 2, 0)); @(negedge clk);
    chk(cfg_rdata == mk(1, 12'hABC, 1, 2, 0), "R2", cfg_rdata, mk(1, 12'hABC, 1, 2, 0));
    wr(mk(0, 12'h543, 0, 1, 1)); @(negedge clk);
    chk(cfg_rdata == mk(0, 12'h543, 0, 1, 1), "R2", cfg_rdata, mk(0, 12'h543, 0, 1, 1));

    // R3 / R5: sweep of field with internal source, no prescaler
    for (int f = 0; f <= 40; f++) begin
      wr(mk(0, f, 0, 0, 1));
      wait_tick();
      meas(per, hi);
      chk(per == f + 1, "R3", per, f + 1);
      chk(hi == (f + 2) / 2, "R5", hi, (f + 2) / 2);
    end

    // R4: prescaled sweep
    for (int f = 0; f <= 6; f++) begin
      wr(mk(0, f, 1, 0, 1));
      wait_tick();
      meas(per, hi);
      chk(per == 16 * (f + 1), "R4", per, 16 * (f + 1));
      chk(hi == 16 * ((f + 2) / 2), "R5", hi, 16 * ((f + 2) / 2));
    end
    // R4 with encoder-derived word for ratio 4112
    ratio_req = 17'd4112; #1;
    wr(mk(0, enc_count, enc_div16, 0, 1));
    wait_tick();
    meas(per, hi);
    chk(per == 4112, "R4", per, 4112);

    // R8: external sources
    wr(mk(0, 3, 0, 1, 1)); wait_tick(); meas(per, hi);
    chk(per == 12, "R8", per, 12);
    wr(mk(0, 3, 0, 2, 1)); wait_tick(); meas(per, hi);
    chk(per == 20, "R8", per, 20);
    wr(mk(0, 3, 0, 3, 1)); wait_tick(); meas(per, hi);
    chk(per == 8, "R8", per, 8);

    // R6: hold bit
    wr(mk(1, 4, 0, 0, 1));
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (out_tick || out_clk) n++;
    end
    chk(n == 0, "R6", n, 0);
    wr(mk(0, 4, 0, 0, 1));
    chk(cfg_rdata[0] == 1'b0, "R2", cfg_rdata[0], 0);
    n = 0;
    while (!out_tick) begin @(negedge clk); n++; end
    chk(n == 5, "R6", n, 5);

    // R7: disable freezes output and keeps count
    wr(mk(0, 4, 0, 0, 0));
    n = 0;
    begin
      logic held;
      held = out_clk;
      repeat (50) begin
        @(negedge clk);
        if (out_tick || out_clk != held) n++;
      end
    end
    chk(n == 0, "R7", n, 0);
    chk(cfg_rdata[12:1] == 12'd4, "R7", cfg_rdata[12:1], 4);
    wr(mk(0, 4, 0, 0, 1));
    wait_tick(); meas(per, hi);
    chk(per == 5, "R7", per, 5);

    // R9: change count mid-period
    wr(mk(0, 9, 0, 0, 1));
    wait_tick(); wait_tick();
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    wr(mk(0, 3, 0, 0, 1)); n += 2;
    while (!out_tick) begin @(negedge clk); n++; end
    chk(n == 10, "R9", n, 10);
    n = 0;
    do begin @(negedge clk); n++; end while (!out_tick);
    chk(n == 4, "R9", n, 4);

    // R10: exhaustive encoder sweep
    begin
      int errs = 0;
      for (int r = 1; r <= 65536; r++) begin
        int ed, ec;
        ratio_req = 17'(r); #1;
        ed = (r > 4096) ? 1 : 0;
        ec = (r > 4096) ? (r / 16 - 1) : (r - 1);
        if (enc_div16 != ed[0] || enc_count != 12'(ec)) begin
          errs++;
          if (errs < 4) chk(0, "R10", {enc_div16, enc_count}, ec);
        end
      end
      chk(errs == 0, "R10", errs, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule